// File: doc/BRIEF.md
# VME A24/D16 Slave Transfer Controller

This block lets a board answer single 16-bit data cycles from a VME master using 24-bit addressing. When the master pulls the address strobe low, the controller registers the address and address modifier and shows them on a pair of decode outputs. An address decoder outside the block looks at those values and raises a hit input. The hit must come within a fixed number of clock cycles. If no hit arrives in that time, the controller stays silent for the rest of the bus cycle.

On a hit, the controller drives a request to a synchronous user port together with the address, modifier, a read/write flag, byte enables and write data. It waits for the port's ready. For a read it registers the returned data onto the bus data output. It then pulls the data acknowledge low and holds it until the master lets go of the address strobe. The block also drives the enables and the direction of the data transceivers.

All bus control inputs pass through two-flop synchronizers before the state machine sees them. A bus error seen during an active cycle ends the cycle at once, with no acknowledge. An interrupt-acknowledge cycle gets no data-transfer response.

Top module: `vme_a24d16_slave`

## Requirements
- R1: Once the synchronized address strobe falls, the address bits [23:1] and the 6-bit modifier are registered onto `dec_addr`/`dec_am` (also `usr_addr`/`usr_am`). They are held until the next cycle starts.
- R2: The byte enables follow the data strobes. Strobe 0 low sets `usr_be_lo` (bits [7:0]). Strobe 1 low sets `usr_be_hi` (bits [15:8]). Both low set both enables. The long-word input and address bit 1 (`bus_addr[0]`) have no effect on the enables.
- R3: `usr_req` stays high until `usr_rdy` is seen high. While it is high, `usr_addr`, `usr_am`, `usr_wdata`, the enables and `usr_rd_wr_n` (1 = read, 0 = write) do not change.
- R4: On a read, the `usr_rdata` value present with `usr_rdy` appears on `bus_data_out` in the same cycle that `bus_dtack_n` goes low. It stays there even if `usr_rdata` changes afterwards.
- R5: `bus_dtack_n` goes low only in the cycle after the ready handshake and never while `usr_req` is high. It stays low while the address strobe stays low. It goes high on the third clock edge after the strobe rises.
- R6: `dec_hit` must be seen within `DEC_CYC` (default 2) cycles after the captured address appears. A missing or late hit gives no request and no acknowledge for that bus cycle.
- R7: A bus error (`bus_berr_n` low) during decode, request or acknowledge ends the cycle. The request is dropped and no acknowledge is given.
- R8: A cycle with the interrupt-acknowledge input low gets no request and no acknowledge.
- R9: Transceiver control on a read: `xcvr_dir`=1, `xcvr_int_oe_n`=0 and `xcvr_ext_oe_n`=0 only while acknowledging; all enables go high in the same cycle the acknowledge is released. Transceiver control on a write: `xcvr_ext_oe_n`=0 and `xcvr_dir`=0 during request and acknowledge, with `xcvr_int_oe_n` kept high. At all other times both enables are high and `xcvr_dir` is 0.
- R10: The reset `rst_n` is asynchronous and active low. It leaves `bus_dtack_n`, `xcvr_ext_oe_n` and `xcvr_int_oe_n` high, `usr_req` and `xcvr_dir` low, and `dec_addr`/`dec_am` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 23 | Bus address bits [23:1] |
| bus_am | input | 6 | Bus address modifier |
| bus_data_in | input | 16 | Write data from the bus |
| bus_data_out | output | 16 | Read data toward the bus |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds0_n | input | 1 | Data strobe for bits [7:0], active low |
| bus_ds1_n | input | 1 | Data strobe for bits [15:8], active low |
| bus_lword_n | input | 1 | Long-word flag, ignored |
| bus_write_n | input | 1 | Direction from master, low = write |
| bus_iack_n | input | 1 | Interrupt acknowledge cycle, active low |
| bus_berr_n | input | 1 | Bus error, active low |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| xcvr_ext_oe_n | output | 1 | External transceiver enable, active low |
| xcvr_int_oe_n | output | 1 | Internal driver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward bus |
| dec_addr | output | 23 | Registered address for the external decoder |
| dec_am | output | 6 | Registered modifier for the external decoder |
| dec_hit | input | 1 | Decoder reports this board is addressed |
| usr_req | output | 1 | User port access request |
| usr_rdy | input | 1 | User port ready |
| usr_addr | output | 23 | User port address |
| usr_am | output | 6 | User port address modifier |
| usr_wdata | output | 16 | User port write data |
| usr_rdata | input | 16 | User port read data |
| usr_rd_wr_n | output | 1 | 1 = read, 0 = write |
| usr_be_lo | output | 1 | Byte enable for bits [7:0] |
| usr_be_hi | output | 1 | Byte enable for bits [15:8] |

## Verification
The bench holds ready low for several cycles. A controller that acknowledges early or drops the request would then show `bus_dtack_n` low or `usr_req` low too soon. Each single-strobe pattern is run with the long-word flag and address bit 1 set. Lane logic that reads those inputs, or swaps the strobes, would then give the wrong enables. Read data is changed after the handshake, so a transparent output path would be exposed. The release of the acknowledge is checked on an exact cycle count after the strobe rises. The no-response cases are a modifier the decoder rejects, a hit that arrives after the window, an interrupt-acknowledge cycle and a bus error during the request. In each case a design that ignores the condition would raise a request or an acknowledge.

// File: rtl/vslv_pkg.sv
package vslv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_REQUEST,
        ST_ACK,
        ST_WAIT_AS
    } vslv_state_e;

    // positions inside the synchronized control vector
    localparam int SIG_AS    = 0;
    localparam int SIG_DS0   = 1;
    localparam int SIG_DS1   = 2;
    localparam int SIG_WRITE = 3;
    localparam int SIG_IACK  = 4;
    localparam int SIG_BERR  = 5;
    localparam int SIG_COUNT = 6;

    typedef struct packed {
        logic hi;
        logic lo;
    } lane_sel_t;

    typedef struct packed {
        lane_sel_t lanes;
        logic      rd;
    } xfer_attr_t;

    typedef struct packed {
        logic ext_oe_n;
        logic int_oe_n;
        logic dir;
    } xcvr_ctl_t;

    function automatic lane_sel_t lanes_from_strobes(input logic ds0_n, input logic ds1_n);
        lane_sel_t r;
        r.lo = ~ds0_n;
        r.hi = ~ds1_n;
        return r;
    endfunction

    function automatic xcvr_ctl_t xcvr_for(input vslv_state_e st, input logic is_read);
        xcvr_ctl_t r;
        r = '{ext_oe_n: 1'b1, int_oe_n: 1'b1, dir: 1'b0};
        if (is_read) begin
            if (st == ST_ACK) r = '{ext_oe_n: 1'b0, int_oe_n: 1'b0, dir: 1'b1};
        end else if (st == ST_REQUEST || st == ST_ACK) begin
            r.ext_oe_n = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/vslv_sync.sv
module vslv_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/vslv_fsm.sv
module vslv_fsm
    import vslv_pkg::*;
#(
    parameter int DEC_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        as_n_s,
    input  logic        ds_any_s,
    input  logic        iack_n_s,
    input  logic        berr_n_s,
    input  logic        dec_hit,
    input  logic        usr_rdy,
    output vslv_state_e state,
    output logic        capture_en,
    output logic        launch_en,
    output logic        load_rd
);
    localparam int             CNT_W = $clog2(DEC_CYC + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DEC_CYC - 1);

    vslv_state_e      nxt;
    logic             as_prev;
    logic             hit_seen;
    logic             hit_now;
    logic             win_done;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        hit_now    = hit_seen | dec_hit;
        win_done   = (cnt == LAST);
        nxt        = state;
        capture_en = 1'b0;
        launch_en  = 1'b0;
        load_rd    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (!as_n_s && as_prev) begin
                    capture_en = 1'b1;
                    nxt        = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (!berr_n_s || as_n_s || !iack_n_s) begin
                    nxt = ST_WAIT_AS;
                end else if (win_done) begin
                    if (!hit_now) begin
                        nxt = ST_WAIT_AS;
                    end else if (ds_any_s) begin
                        launch_en = 1'b1;
                        nxt       = ST_REQUEST;
                    end
                end
            end
            ST_REQUEST: begin
                if (!berr_n_s) begin
                    nxt = ST_WAIT_AS;
                end else if (usr_rdy) begin
                    load_rd = 1'b1;
                    nxt     = ST_ACK;
                end
            end
            ST_ACK: begin
                if (!berr_n_s || as_n_s) nxt = ST_WAIT_AS;
            end
            ST_WAIT_AS: begin
                if (as_n_s) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            as_prev  <= 1'b1;
            cnt      <= '0;
            hit_seen <= 1'b0;
        end else begin
            state   <= nxt;
            as_prev <= as_n_s;
            if (capture_en) begin
                cnt      <= '0;
                hit_seen <= 1'b0;
            end else if (state == ST_DECODE && !win_done) begin
                cnt      <= cnt + 1'b1;
                hit_seen <= hit_now;
            end else if (state == ST_DECODE && hit_now) begin
                hit_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vslv_datapath.sv
module vslv_datapath
    import vslv_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int AM_W   = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              launch_en,
    input  logic              load_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [AM_W-1:0]   bus_am,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              ds0_n_s,
    input  logic              ds1_n_s,
    input  logic              write_n_s,
    input  logic [DATA_W-1:0] usr_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [AM_W-1:0]   am_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output xfer_attr_t        attr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            am_q    <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            attr_q  <= '0;
        end else begin
            if (capture_en) begin
                addr_q <= bus_addr;
                am_q   <= bus_am;
            end
            if (launch_en) begin
                attr_q.lanes <= lanes_from_strobes(ds0_n_s, ds1_n_s);
                attr_q.rd    <= write_n_s;
                wdata_q      <= bus_data_in;
            end
            if (load_rd && attr_q.rd) rdata_q <= usr_rdata;
        end
    end
endmodule

// File: rtl/vme_a24d16_slave.sv
module vme_a24d16_slave
    import vslv_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int AM_W    = 6,
    parameter int DATA_W  = 16,
    parameter int DEC_CYC = 2,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [AM_W-1:0]   bus_am,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [DATA_W-1:0] bus_data_out,
    input  logic              bus_as_n,
    input  logic              bus_ds0_n,
    input  logic              bus_ds1_n,
    input  logic              bus_lword_n,
    input  logic              bus_write_n,
    input  logic              bus_iack_n,
    input  logic              bus_berr_n,
    output logic              bus_dtack_n,
    output logic              xcvr_ext_oe_n,
    output logic              xcvr_int_oe_n,
    output logic              xcvr_dir,
    output logic [ADDR_W-1:0] dec_addr,
    output logic [AM_W-1:0]   dec_am,
    input  logic              dec_hit,
    output logic              usr_req,
    input  logic              usr_rdy,
    output logic [ADDR_W-1:0] usr_addr,
    output logic [AM_W-1:0]   usr_am,
    output logic [DATA_W-1:0] usr_wdata,
    input  logic [DATA_W-1:0] usr_rdata,
    output logic              usr_rd_wr_n,
    output logic              usr_be_lo,
    output logic              usr_be_hi
);
    logic [SIG_COUNT-1:0] ctl_raw;
    logic [SIG_COUNT-1:0] ctl_s;
    vslv_state_e          state;
    logic                 capture_en;
    logic                 launch_en;
    logic                 load_rd;
    logic [ADDR_W-1:0]    addr_q;
    logic [AM_W-1:0]      am_q;
    xfer_attr_t           attr_q;
    xcvr_ctl_t            xcvr;
    logic                 unused_lword;

    // long-word flag plays no part in a 16-bit slave
    assign unused_lword = bus_lword_n;

    always_comb begin
        ctl_raw            = '1;
        ctl_raw[SIG_AS]    = bus_as_n;
        ctl_raw[SIG_DS0]   = bus_ds0_n;
        ctl_raw[SIG_DS1]   = bus_ds1_n;
        ctl_raw[SIG_WRITE] = bus_write_n;
        ctl_raw[SIG_IACK]  = bus_iack_n;
        ctl_raw[SIG_BERR]  = bus_berr_n;
    end

    vslv_sync #(
        .WIDTH  (SIG_COUNT),
        .STAGES (SYNC_N),
        .RST_VAL({SIG_COUNT{1'b1}})
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(ctl_raw),
        .q_sync (ctl_s)
    );

    vslv_fsm #(
        .DEC_CYC(DEC_CYC)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n_s    (ctl_s[SIG_AS]),
        .ds_any_s  (~(ctl_s[SIG_DS0] & ctl_s[SIG_DS1])),
        .iack_n_s  (ctl_s[SIG_IACK]),
        .berr_n_s  (ctl_s[SIG_BERR]),
        .dec_hit   (dec_hit),
        .usr_rdy   (usr_rdy),
        .state     (state),
        .capture_en(capture_en),
        .launch_en (launch_en),
        .load_rd   (load_rd)
    );

    vslv_datapath #(
        .ADDR_W(ADDR_W),
        .AM_W  (AM_W),
        .DATA_W(DATA_W)
    ) dp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .launch_en  (launch_en),
        .load_rd    (load_rd),
        .bus_addr   (bus_addr),
        .bus_am     (bus_am),
        .bus_data_in(bus_data_in),
        .ds0_n_s    (ctl_s[SIG_DS0]),
        .ds1_n_s    (ctl_s[SIG_DS1]),
        .write_n_s  (ctl_s[SIG_WRITE]),
        .usr_rdata  (usr_rdata),
        .addr_q     (addr_q),
        .am_q       (am_q),
        .wdata_q    (usr_wdata),
        .rdata_q    (bus_data_out),
        .attr_q     (attr_q)
    );

    assign xcvr          = xcvr_for(state, attr_q.rd);
    assign xcvr_ext_oe_n = xcvr.ext_oe_n;
    assign xcvr_int_oe_n = xcvr.int_oe_n;
    assign xcvr_dir      = xcvr.dir;

    assign bus_dtack_n = (state != ST_ACK);
    assign usr_req     = (state == ST_REQUEST);
    assign dec_addr    = addr_q;
    assign dec_am      = am_q;
    assign usr_addr    = addr_q;
    assign usr_am      = am_q;
    assign usr_rd_wr_n = attr_q.rd;
    assign usr_be_lo   = attr_q.lanes.lo;
    assign usr_be_hi   = attr_q.lanes.hi;
endmodule

// File: rtl/vslv_checker.sv
module vslv_checker #(
    parameter int ADDR_W = 23,
    parameter int AM_W   = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_as_n,
    input logic              bus_berr_n,
    input logic              bus_dtack_n,
    input logic              xcvr_int_oe_n,
    input logic              xcvr_ext_oe_n,
    input logic              xcvr_dir,
    input logic              usr_req,
    input logic              usr_rdy,
    input logic [ADDR_W-1:0] usr_addr,
    input logic [AM_W-1:0]   usr_am,
    input logic [DATA_W-1:0] usr_wdata,
    input logic              usr_be_lo,
    input logic              usr_be_hi
);
    // R5: request and acknowledge never overlap
    p_no_req_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(usr_req && !bus_dtack_n));

    // R5: acknowledge falls only after a request met ready
    p_ack_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_dtack_n) |-> $past(usr_req && usr_rdy));

    // R5: acknowledge held while strobe stays low and no bus error
    p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_dtack_n && !$past(bus_as_n) && $past(bus_berr_n)) |=> !bus_dtack_n);

    // R3: request fields stay still while the request is up
    p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_req && $past(usr_req)) |-> ($stable(usr_addr) && $stable(usr_am) && $stable(usr_wdata)));

    // R2: a request always carries at least one lane
    p_req_has_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        usr_req |-> (usr_be_lo || usr_be_hi));

    // R9: internal driver only on while acknowledging toward the bus
    p_int_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_int_oe_n |-> (!bus_dtack_n && xcvr_dir && !xcvr_ext_oe_n));
endmodule

bind vme_a24d16_slave vslv_checker #(
    .ADDR_W(ADDR_W),
    .AM_W  (AM_W),
    .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/vme_a24d16_slave_tb_top.sv
module vme_a24d16_slave_tb_top;
    localparam logic [5:0] AM_OK = 6'h3D;
    localparam logic [6:0] BASE  = 7'h12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [22:0] bus_addr = '0;
    logic [5:0]  bus_am = '0;
    logic [15:0] bus_data_in = '0;
    logic [15:0] bus_data_out;
    logic        bus_as_n = 1'b1, bus_ds0_n = 1'b1, bus_ds1_n = 1'b1, bus_lword_n = 1'b1;
    logic        bus_write_n = 1'b1, bus_iack_n = 1'b1, bus_berr_n = 1'b1;
    logic        bus_dtack_n, xcvr_ext_oe_n, xcvr_int_oe_n, xcvr_dir;
    logic [22:0] dec_addr, usr_addr;
    logic [5:0]  dec_am, usr_am;
    logic        dec_hit, usr_req, usr_rdy = 1'b0;
    logic [15:0] usr_wdata, usr_rdata = '0;
    logic        usr_rd_wr_n, usr_be_lo, usr_be_hi;
    logic        hit_en = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // board decoder model outside the block
    assign dec_hit = hit_en && (dec_am == AM_OK) && (dec_addr[22:16] == BASE);

    vme_a24d16_slave dut_i (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic start_cycle(input logic [22:0] a, input logic [5:0] am, input logic wr_n,
                               input logic ds0, input logic ds1, input logic [15:0] wd,
                               input logic lw, input logic iack);
        @(negedge clk);
        bus_addr = a; bus_am = am; bus_write_n = wr_n; bus_data_in = wd;
        bus_lword_n = lw; bus_iack_n = iack;
        bus_ds0_n = ds0; bus_ds1_n = ds1; bus_as_n = 1'b0;
    endtask

    task automatic end_cycle();
        @(negedge clk);
        bus_as_n = 1'b1; bus_ds0_n = 1'b1; bus_ds1_n = 1'b1; bus_iack_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_req(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 15 && !seen; i++) begin
            @(negedge clk);
            if (usr_req) seen = 1'b1;
        end
    endtask

    task automatic silent_window(input string tag);
        bit quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (usr_req || !bus_dtack_n) quiet = 1'b0;
        end
        check(tag, quiet, 1'b1);
    endtask

    task automatic release_and_check(input string tag);
        @(negedge clk);
        bus_as_n = 1'b1; bus_ds0_n = 1'b1; bus_ds1_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check({tag, " R5 dtack held 2 cycles after AS rise"}, bus_dtack_n, 1'b0);
        @(negedge clk);
        check({tag, " R5 dtack released"}, bus_dtack_n, 1'b1);
        check({tag, " R9 drivers off with ack"}, {xcvr_int_oe_n, xcvr_ext_oe_n, xcvr_dir}, 3'b110);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 dtack", bus_dtack_n, 1'b1);
        check("R10 req", usr_req, 1'b0);
        check("R10 xcvr", {xcvr_ext_oe_n, xcvr_int_oe_n, xcvr_dir}, 3'b110);
        check("R10 dec regs", {dec_addr, dec_am}, '0);
    endtask

    task automatic t_write(input logic ds0, input logic ds1, input logic [15:0] wd, input logic a1);
        bit seen;
        logic [22:0] a = {BASE, 15'h0ABC, a1} >> 1;
        a = {BASE, a[15:0]};
        a[0] = a1;
        start_cycle(a, AM_OK, 1'b0, ds0, ds1, wd, 1'b0, 1'b1);
        wait_req(seen);
        check("R6 hit in window gives request", seen, 1'b1);
        check("R1 dec_addr", dec_addr, a);
        check("R1 dec_am", dec_am, AM_OK);
        check("R2 byte enables (lword/a1 ignored)", {usr_be_hi, usr_be_lo}, {~ds1, ~ds0});
        check("R3 write fields", {usr_rd_wr_n, usr_wdata, usr_addr}, {1'b0, wd, a});
        check("R9 write xcvr", {xcvr_ext_oe_n, xcvr_int_oe_n, xcvr_dir}, 3'b010);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R3 req held w/o ready", {usr_req, bus_dtack_n}, 2'b11);
        end
        usr_rdy = 1'b1;
        @(negedge clk);
        usr_rdy = 1'b0;
        check("R5 ack after ready", {usr_req, bus_dtack_n}, 2'b00);
        repeat (5) @(negedge clk);
        check("R5 ack held while AS low", bus_dtack_n, 1'b0);
        release_and_check("write");
    endtask

    task automatic t_read(input logic [15:0] rd);
        bit seen;
        logic [22:0] a = {BASE, 16'h4402};
        start_cycle(a, AM_OK, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1);
        wait_req(seen);
        check("R3 read request", {seen, usr_rd_wr_n}, 2'b11);
        check("R9 read xcvr idle during request", {xcvr_ext_oe_n, xcvr_int_oe_n, xcvr_dir}, 3'b110);
        repeat (2) @(negedge clk);
        usr_rdy = 1'b1; usr_rdata = rd;
        @(negedge clk);
        usr_rdy = 1'b0; usr_rdata = ~rd;
        check("R4 data with ack", {bus_dtack_n, bus_data_out}, {1'b0, rd});
        check("R9 read ack xcvr", {xcvr_ext_oe_n, xcvr_int_oe_n, xcvr_dir}, 3'b001);
        repeat (3) @(negedge clk);
        check("R4 data held", bus_data_out, rd);
        release_and_check("read");
    endtask

    task automatic t_miss();
        start_cycle({BASE, 16'h0010}, 6'h39, 1'b0, 1'b0, 1'b0, 16'h1111, 1'b1, 1'b1);
        silent_window("R6 rejected modifier gives no response");
        end_cycle();
    endtask

    task automatic t_late();
        hit_en = 1'b0;
        start_cycle({BASE, 16'h0020}, AM_OK, 1'b0, 1'b0, 1'b0, 16'h2222, 1'b1, 1'b1);
        repeat (6) @(negedge clk);
        hit_en = 1'b1;
        silent_window("R6 late hit gives no response");
        end_cycle();
    endtask

    task automatic t_iack();
        start_cycle({BASE, 16'h0005}, AM_OK, 1'b1, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        silent_window("R8 iack cycle ignored");
        end_cycle();
    endtask

    task automatic t_berr();
        bit seen;
        bit dropped = 1'b0;
        bit acked = 1'b0;
        start_cycle({BASE, 16'h0030}, AM_OK, 1'b0, 1'b0, 1'b0, 16'h3333, 1'b1, 1'b1);
        wait_req(seen);
        check("R7 request before error", seen, 1'b1);
        bus_berr_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!usr_req) dropped = 1'b1;
        end
        usr_rdy = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!bus_dtack_n) acked = 1'b1;
        end
        usr_rdy = 1'b0;
        check("R7 request dropped on bus error", dropped, 1'b1);
        check("R7 no ack on bus error", acked, 1'b0);
        bus_berr_n = 1'b1;
        end_cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_write(1'b0, 1'b1, 16'h00A5, 1'b1);
        t_write(1'b1, 1'b0, 16'h5A00, 1'b1);
        t_write(1'b0, 1'b0, 16'hBEEF, 1'b0);
        t_read(16'hC3E1);
        t_miss();
        t_late();
        t_iack();
        t_berr();
        t_read(16'h0F0F);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule